// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port whose frames hold eleven bits. Each frame has a low start bit, eight data bits with the least significant bit first, a ninth data bit, and a high stop bit. Software drives the block through a small register file. A write to the data register starts a transmission. The ninth transmitted bit comes from a control bit, which can carry parity or a flag. Reads return the last received byte, the received ninth bit, and two completion flags. Software clears each flag by writing zero to it.

Bit timing comes from a baud tick that runs at sixteen ticks per bit. In fixed mode the tick is derived from the core clock, giving a bit rate of clock/32, or clock/16 when the double-rate bit is set. In variable mode a two-bit source field picks one of two sources. The first is an external timer overflow pulse, which is halved when the double-rate bit is set. The second is an internal 16-bit reload down-counter whose reload value is written as two bytes.

The receiver waits for a falling edge on its synchronised input, and only while reception is enabled. It checks the start bit again at the middle of the bit and then samples every later bit at its centre.

Top module: `uart9_core`

Register map (address on `wr_addr`/`rd_addr`):
- 0 control: bit 0 variable mode, bit 1 receive enable, bit 2 ninth transmit bit, bit 3 double rate, bits 5:4 source select (2'b01 = internal generator, any other value = timer pulse).
- 1 status: bit 0 received ninth bit, bit 1 transmit done, bit 2 receive done. A write with bit 1 or bit 2 at 0 clears that flag. A write with the bit at 1 leaves the flag unchanged.
- 2 data: a write starts a transmission; a read returns the received byte.
- 3 rate low byte, 4 rate high byte.

## Requirements
- R1: When idle, `txd` is 1. A transmission sends 0, then data bits 0 through 7, then control bit 2, then 1. Each bit lasts sixteen ticks.
- R2: The transmit-done flag (status bit 1) sets when the stop bit begins. It stays set until software writes status with bit 1 at 0.
- R3: A received frame with a high stop bit places its byte in the data register and its ninth bit in status bit 0. It also sets the receive-done flag (status bit 2), which stays set until software writes status with bit 2 at 0.
- R4: When control bit 1 is 0, activity on `rxd` changes neither the receive buffer nor the receive-done flag.
- R5: A low pulse on `rxd` that ends before the middle of the start bit returns the receiver to idle without setting receive-done. The receiver can then take the next frame.
- R6: A frame whose stop bit reads 0 leaves the receive buffer and the receive-done flag unchanged.
- R7: In fixed mode a bit lasts 32 clocks, or 16 clocks when control bit 3 is 1.
- R8: In variable mode with the timer source, a bit lasts 16 overflow pulses, or 32 pulses when control bit 3 is 1.
- R9: In variable mode with the generator source, a bit lasts 16*(N+1) clocks, where N is the 16-bit rate value. Writing either rate byte restarts the counter.
- R10: A data write while a transmission is in progress is ignored.
- R11: After reset `txd` is 1 and the control and status registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | synchronous active-low reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | register write address |
| wr_data | input | 8 | register write data |
| rd_addr | input | 3 | register read address |
| rd_data | output | 8 | register read data (combinational) |
| timer_ovf | input | 1 | one-clock timer overflow pulse |
| rxd | input | 1 | serial receive line |
| txd | output | 1 | serial transmit line |

## Verification
The bench measures the length of a single data bit on `txd` under each timing source. A divider that is off by one, or a double-rate halving applied the wrong way, therefore shows up as a wrong clock count instead of a garbled frame. It sends a start glitch shorter than half a bit, a frame with a low stop bit, and a frame while reception is disabled. A receiver that skips the mid-start check, commits on a bad stop bit, or ignores the enable would then flag reception or overwrite the buffer. A second data write during a busy transmission would corrupt a looped-back frame if it were accepted. Flag clearing is checked through the status register.

// File: rtl/uart9_pkg.sv
// Package: register addresses, control bit positions and frame constants
// shared by the transceiver modules. Assumes an 8-bit register file.
package uart9_pkg;
    localparam int ADDR_W    = 3;
    localparam int REG_W     = 8;
    localparam int RATE_W    = 16;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_DATA = 3'd2;
    localparam logic [ADDR_W-1:0] A_RLO  = 3'd3;
    localparam logic [ADDR_W-1:0] A_RHI  = 3'd4;

    localparam int C_VAR  = 0;
    localparam int C_RXEN = 1;
    localparam int C_TB9  = 2;
    localparam int C_DBL  = 3;
    localparam int C_SRC0 = 4;
    localparam int C_SRC1 = 5;

    localparam int S_RB9  = 0;
    localparam int S_TXD  = 1;
    localparam int S_RXD  = 2;

    localparam logic [1:0] SRC_GEN = 2'b01;

    typedef struct packed {
        logic [1:0] src;
        logic       dbl;
        logic       tb9;
        logic       rx_en;
        logic       var_mode;
    } ctrl_t;
endpackage

// File: rtl/uart9_baud.sv
// Baud tick source: produces a registered one-clock tick at sixteen times
// the bit rate from a fixed divider, an external overflow pulse or an
// internal reload down-counter. Assumes timer_ovf is a one-clock pulse.
module uart9_baud #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              var_mode,
    input  logic              dbl,
    input  logic              src_gen,
    input  logic [RATE_W-1:0] rate,
    input  logic              restart,
    input  logic              timer_ovf,
    output logic              tick
);
    logic              half_q;
    logic              par_q;
    logic [RATE_W-1:0] cnt_q;
    logic              gen_hit;
    logic              tmr_hit;
    logic              fix_hit;
    logic              nxt;

    // Select the tick source for the next cycle.
    always_comb begin
        gen_hit = (cnt_q == '0) && !restart;
        tmr_hit = timer_ovf && (!dbl || par_q);
        fix_hit = dbl || half_q;
        if (!var_mode)
            nxt = fix_hit;
        else if (src_gen)
            nxt = gen_hit;
        else
            nxt = tmr_hit;
    end

    // Divider phase, overflow parity, generator counter and tick register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            par_q  <= 1'b0;
            cnt_q  <= '0;
            tick   <= 1'b0;
        end else begin
            half_q <= ~half_q;
            if (timer_ovf)
                par_q <= ~par_q;
            if (restart || cnt_q == '0)
                cnt_q <= rate;
            else
                cnt_q <= cnt_q - 1'b1;
            tick <= nxt;
        end
    end
endmodule

// File: rtl/uart9_tx.sv
// Transmitter: shifts out start, eight data bits, ninth bit and stop, each
// held for TPB ticks. Assumes start is only raised while busy is low.
module uart9_tx #(
    parameter int DW  = 8,
    parameter int TPB = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic [DW-1:0] data,
    input  logic          bit9,
    output logic          txd,
    output logic          busy,
    output logic          stop_begin
);
    localparam int NBITS = DW + 3;
    localparam int TW    = $clog2(TPB);
    localparam int BW    = $clog2(NBITS);

    logic [DW+1:0] sh_q;
    logic [TW-1:0] tcnt_q;
    logic [BW-1:0] bitn_q;

    // Frame sequencer: load, advance one bit per TPB ticks, finish after stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q       <= '0;
            tcnt_q     <= '0;
            bitn_q     <= '0;
            busy       <= 1'b0;
            txd        <= 1'b1;
            stop_begin <= 1'b0;
        end else begin
            stop_begin <= 1'b0;
            if (start && !busy) begin
                sh_q   <= {1'b1, bit9, data};
                tcnt_q <= '0;
                bitn_q <= '0;
                busy   <= 1'b1;
                txd    <= 1'b0;
            end else if (busy && tick) begin
                tcnt_q <= tcnt_q + 1'b1;
                if (tcnt_q == TW'(TPB - 1)) begin
                    if (bitn_q == BW'(NBITS - 1)) begin
                        busy <= 1'b0;
                        txd  <= 1'b1;
                    end else begin
                        txd    <= sh_q[0];
                        sh_q   <= {1'b0, sh_q[DW+1:1]};
                        bitn_q <= bitn_q + 1'b1;
                        if (bitn_q == BW'(NBITS - 2))
                            stop_begin <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uart9_rx.sv
// Receiver: synchronises rxd, detects a start edge while enabled, confirms
// it at mid-bit and samples each later bit at its centre. Reports a frame
// only when its stop bit is high.
module uart9_rx #(
    parameter int DW  = 8,
    parameter int TPB = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          rxd,
    output logic [DW-1:0] data,
    output logic          bit9,
    output logic          done
);
    localparam int NBITS = DW + 3;
    localparam int TW    = $clog2(TPB);
    localparam int BW    = $clog2(NBITS);
    localparam int MID   = TPB / 2 - 1;

    logic [1:0]    sync_q;
    logic          run_q;
    logic [TW-1:0] tcnt_q;
    logic [BW-1:0] bitn_q;
    logic [DW-1:0] sh_q;
    logic          b9_q;
    logic          rs;

    assign rs = sync_q[1];

    // Two-stage input synchroniser, idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    // Frame sampler: start check, data shift, ninth bit, stop qualification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            tcnt_q <= '0;
            bitn_q <= '0;
            sh_q   <= '0;
            b9_q   <= 1'b0;
            data   <= '0;
            bit9   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!run_q) begin
                if (en && !rs) begin
                    run_q  <= 1'b1;
                    tcnt_q <= '0;
                    bitn_q <= '0;
                end
            end else if (tick) begin
                tcnt_q <= tcnt_q + 1'b1;
                if (tcnt_q == TW'(TPB - 1))
                    bitn_q <= bitn_q + 1'b1;
                if (tcnt_q == TW'(MID)) begin
                    if (bitn_q == '0) begin
                        if (rs) run_q <= 1'b0;
                    end else if (bitn_q <= BW'(DW)) begin
                        sh_q <= {rs, sh_q[DW-1:1]};
                    end else if (bitn_q == BW'(DW + 1)) begin
                        b9_q <= rs;
                    end else begin
                        run_q <= 1'b0;
                        if (rs) begin
                            data <= sh_q;
                            bit9 <= b9_q;
                            done <= 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uart9_core.sv
// Top: register file, flag handling and the three engines. Assumes one
// register write per cycle; reads are combinational and have no side effect.
module uart9_core
    import uart9_pkg::*;
#(
    parameter int TPB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              timer_ovf,
    input  logic              rxd,
    output logic              txd
);
    ctrl_t             ctrl_q;
    logic [RATE_W-1:0] rate_q;
    logic              restart_q;
    logic              tx_done_q;
    logic              rx_done_q;
    logic              tick;
    logic              tx_busy;
    logic              tx_stop;
    logic              tx_go;
    logic [REG_W-1:0]  rx_byte;
    logic              rx_b9;
    logic              rx_fin;
    logic              var_mode;
    logic              dbl;
    logic              src_gen;
    logic              wr_stat;

    assign var_mode = ctrl_q.var_mode;
    assign dbl      = ctrl_q.dbl;
    assign src_gen  = (ctrl_q.src == SRC_GEN);
    assign tx_go    = wr_en && (wr_addr == A_DATA) && !tx_busy;
    assign wr_stat  = wr_en && (wr_addr == A_STAT);

    // Control and rate registers; a rate write requests a generator restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            rate_q    <= '0;
            restart_q <= 1'b0;
        end else begin
            restart_q <= 1'b0;
            if (wr_en && wr_addr == A_CTRL)
                ctrl_q <= ctrl_t'(wr_data[5:0]);
            if (wr_en && wr_addr == A_RLO) begin
                rate_q[7:0] <= wr_data;
                restart_q   <= 1'b1;
            end
            if (wr_en && wr_addr == A_RHI) begin
                rate_q[15:8] <= wr_data;
                restart_q    <= 1'b1;
            end
        end
    end

    // Done flags: set by the engines, cleared by writing zero; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_done_q <= 1'b0;
            rx_done_q <= 1'b0;
        end else begin
            if (tx_stop)
                tx_done_q <= 1'b1;
            else if (wr_stat && !wr_data[S_TXD])
                tx_done_q <= 1'b0;
            if (rx_fin)
                rx_done_q <= 1'b1;
            else if (wr_stat && !wr_data[S_RXD])
                rx_done_q <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = {2'b00, ctrl_q};
            A_STAT:  rd_data = {5'b0, rx_done_q, tx_done_q, rx_b9};
            A_DATA:  rd_data = rx_byte;
            A_RLO:   rd_data = rate_q[7:0];
            A_RHI:   rd_data = rate_q[15:8];
            default: rd_data = '0;
        endcase
    end

    uart9_baud #(.RATE_W(RATE_W)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .var_mode  (var_mode),
        .dbl       (dbl),
        .src_gen   (src_gen),
        .rate      (rate_q),
        .restart   (restart_q),
        .timer_ovf (timer_ovf),
        .tick      (tick)
    );

    uart9_tx #(.DW(REG_W), .TPB(TPB)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .start      (tx_go),
        .data       (wr_data),
        .bit9       (ctrl_q.tb9),
        .txd        (txd),
        .busy       (tx_busy),
        .stop_begin (tx_stop)
    );

    uart9_rx #(.DW(REG_W), .TPB(TPB)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .en    (ctrl_q.rx_en),
        .rxd   (rxd),
        .data  (rx_byte),
        .bit9  (rx_b9),
        .done  (rx_fin)
    );
endmodule

// File: rtl/uart9_core_chk.sv
// Checker bound to uart9_core: temporal properties of line, flags and ticks.
module uart9_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        txd,
    input logic        tx_busy,
    input logic        tx_done_q,
    input logic        tick,
    input logic        var_mode,
    input logic        dbl,
    input logic        src_gen,
    input logic        timer_ovf,
    input logic [15:0] rate_q
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd); // R1

    AST_TXDONE_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done_q) |-> (txd && tx_busy)); // R2

    AST_FIXED_DBL_EVERY_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!var_mode && dbl) |-> tick); // R7

    AST_TIMER_TICK_FROM_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && var_mode && !src_gen && $past(var_mode) && !$past(src_gen))
            |-> $past(timer_ovf)); // R8

    AST_GEN_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && var_mode && src_gen && rate_q != 16'd0 && $stable(rate_q))
            |=> !tick); // R9
endmodule

bind uart9_core uart9_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .txd       (txd),
    .tx_busy   (tx_busy),
    .tx_done_q (tx_done_q),
    .tick      (tick),
    .var_mode  (var_mode),
    .dbl       (dbl),
    .src_gen   (src_gen),
    .timer_ovf (timer_ovf),
    .rate_q    (rate_q)
);

// File: tb/uart9_core_test.sv
module uart9_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       timer_ovf = 1'b0;
    logic       drv_rxd = 1'b1;
    logic       loop = 1'b0;
    logic       ovf_on = 1'b0;
    logic       rxd;
    logic       txd;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done_all = 1'b0;

    assign rxd = loop ? txd : drv_rxd;

    always #2 clk = ~clk;

    uart9_core uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .timer_ovf(timer_ovf), .rxd(rxd), .txd(txd)
    );

    // Overflow pulse every 4 clocks while enabled.
    initial begin
        forever begin
            @(negedge clk); timer_ovf = 1'b0;
            if (ovf_on) begin
                repeat (3) @(negedge clk);
                timer_ovf = 1'b1;
            end
        end
    end

    typedef struct packed { logic [7:0] d; logic b9; } vec_t;
    localparam vec_t VEC [6] = '{
        '{8'h00, 1'b0}, '{8'hFF, 1'b1}, '{8'hA5, 1'b1},
        '{8'h3C, 1'b0}, '{8'h81, 1'b1}, '{8'h7E, 1'b0}};

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); rd_addr = a; #1 d = rd_data;
    endtask

    task automatic wait_flag(input int bitpos, input string req);
        logic [7:0] s;
        int k;
        for (k = 0; k < 5000; k++) begin
            rd(3'd1, s);
            if (s[bitpos]) break;
        end
        if (k == 5000) check(req, 0, 1);
    endtask

    // Length in clocks of data bit 0 (high) of a 0x55 frame on txd.
    task automatic bit0_len(output int len);
        int k;
        len = 0;
        wr(3'd2, 8'h55);
        for (k = 0; k < 20000 && txd; k++) @(negedge clk);
        for (k = 0; k < 20000 && !txd; k++) @(negedge clk);
        for (k = 0; k < 20000 && txd; k++) begin @(negedge clk); len++; end
        wait_flag(1, "R2");
        repeat (len + 8) @(negedge clk);
        wr(3'd1, 8'h00);
    endtask

    task automatic send_rx(input logic [7:0] d, input logic b9, input logic stp);
        logic [10:0] f;
        f = {stp, b9, d, 1'b0};
        for (int i = 0; i < 11; i++) begin
            @(negedge clk); drv_rxd = f[i];
            repeat (15) @(negedge clk);
        end
        @(negedge clk); drv_rxd = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done_all) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int len;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        @(negedge clk);
        check("R11 txd", txd, 1);
        rd(3'd0, r); check("R11 ctrl", r, 0);
        rd(3'd1, r); check("R11 stat", r, 0);

        // Vector loop: fixed double rate, loopback, rx enabled. R1 R3
        loop = 1'b1;
        foreach (VEC[i]) begin
            wr(3'd0, {4'b0, 1'b1, VEC[i].b9, 1'b1, 1'b0});
            wr(3'd2, VEC[i].d);
            wait_flag(2, "R3");
            rd(3'd2, r); check("R1/R3 data", r, VEC[i].d);
            rd(3'd1, r); check("R1/R3 ninth", r[0], VEC[i].b9);
            check("R2 tx_done set", r[1], 1);
            repeat (40) @(negedge clk);
            wr(3'd1, 8'h00);
            rd(3'd1, r); check("R2/R3 flags cleared", r[2:1], 0);
        end

        // R1 explicit serial shape: 0xC3, ninth 1, sample bit centres.
        wr(3'd0, 8'b0000_1100);
        wr(3'd2, 8'hC3);
        begin
            logic [10:0] exp_f, got;
            int k;
            exp_f = {1'b1, 1'b1, 8'hC3, 1'b0};
            for (k = 0; k < 100 && txd; k++) @(negedge clk);
            repeat (7) @(negedge clk);
            for (int i = 0; i < 11; i++) begin
                got[i] = txd;
                repeat (16) @(negedge clk);
            end
            check("R1 frame bits", got, exp_f);
        end
        repeat (20) @(negedge clk);
        wr(3'd1, 8'h00);

        // R10 second write while busy is ignored.
        wr(3'd0, 8'b0000_1010);
        @(negedge clk); wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h5A;
        @(negedge clk); wr_data = 8'hA5;
        @(negedge clk); wr_en = 1'b0;
        repeat (10) @(negedge clk); wr(3'd2, 8'h11);
        wait_flag(2, "R10");
        rd(3'd2, r); check("R10 busy write ignored", r, 8'h5A);
        repeat (40) @(negedge clk);
        wr(3'd1, 8'h00);
        loop = 1'b0;

        // R5 short start glitch, then a valid frame.
        @(negedge clk); drv_rxd = 1'b0;
        repeat (3) @(negedge clk); drv_rxd = 1'b1;
        repeat (60) @(negedge clk);
        rd(3'd1, r); check("R5 glitch no done", r[2], 0);
        rd(3'd2, r); check("R5 buffer kept", r, 8'h5A);
        send_rx(8'h96, 1'b1, 1'b1);
        rd(3'd2, r); check("R5 next frame data", r, 8'h96);
        rd(3'd1, r); check("R5/R3 next frame flags", r[2:0], 3'b101);
        wr(3'd1, 8'h00);

        // R6 bad stop bit.
        send_rx(8'h24, 1'b0, 1'b0);
        rd(3'd2, r); check("R6 buffer kept", r, 8'h96);
        rd(3'd1, r); check("R6 no done", r[2], 0);

        // R4 receiver disabled.
        wr(3'd0, 8'b0000_1000);
        send_rx(8'h3E, 1'b0, 1'b1);
        rd(3'd2, r); check("R4 buffer kept", r, 8'h96);
        rd(3'd1, r); check("R4 no done", r[2], 0);

        // R7 fixed timing.
        wr(3'd0, 8'b0000_0000); bit0_len(len); check("R7 div32", len, 32);
        wr(3'd0, 8'b0000_1000); bit0_len(len); check("R7 div16", len, 16);

        // R8 timer source, overflow every 4 clocks.
        ovf_on = 1'b1;
        wr(3'd0, 8'b0000_0001); bit0_len(len); check("R8 timer", len, 64);
        wr(3'd0, 8'b0000_1001); bit0_len(len); check("R8 timer halved", len, 128);
        ovf_on = 1'b0;

        // R9 internal generator.
        wr(3'd3, 8'd2); wr(3'd4, 8'd0);
        wr(3'd0, 8'b0001_0001); bit0_len(len); check("R9 rate 2", len, 48);
        wr(3'd3, 8'd5); bit0_len(len); check("R9 rate 5 after restart", len, 96);
        rd(3'd3, r); check("R9 rate readback", r, 5);

        done_all = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule